// File: doc/BRIEF.md
# Sequenced-Key Hardware Watchdog

This block is a watchdog timer for a small 8-bit controller. Software drives it through a register write port that recognises two addresses. One is a write-only key register. The other is a control register. The control register holds a 3-bit rate field, a hardware-mode flag, some plain flag bits, and a read-only enable bit in bit 0.

The watchdog starts, or is refreshed, only by an ordered pair of writes to the key register: 0x1E and then 0xE1. The block remembers the last byte written to the key register, whatever that byte was. While enabled, the block advances a 14-bit elapsed counter once every 2^rate machine-cycle ticks. When that counter overflows, the block raises a reset request for one clock, then drops its enable bit and clears its count.

A system integrates the block by feeding the processor's register writes into the port and a one-per-machine-cycle strobe into `tick`. `resetReq` goes to the chip's reset logic. `ctrlValue` is the value software reads back from the control register.

Top module: `seq_watchdog`

## Requirements
- R1: While `rst` is high at a clock edge, all state clears. After that edge, `resetReq` is 0 and `ctrlValue` is 0x00.
- R2: A write to address 0xA7 stores data bits 7..1 into the control register. Bits 7..5 are the rate field, bit 2 is hardware mode, and bits 4, 3 and 1 are plain flags. Data bit 0 is ignored. `ctrlValue[0]` always shows the enable bit.
- R3: The key is valid when three things hold: a byte of 0xE1 is written to address 0xA6, the previous byte written to 0xA6 was 0x1E, and hardware mode is set. A valid key sets the enable bit and clears both the elapsed count and the prescale phase.
- R4: Two cases are ignored. A write of 0xE1 whose previous key-register byte was not 0x1E has no effect. So does a sequence broken by another byte, such as 0x1E, 0x55, 0xE1.
- R5: The last-byte record updates on every write to 0xA6, even while hardware mode is clear. Key writes made while hardware mode is clear never enable the watchdog. A 0x1E written while hardware mode is clear, followed by setting hardware mode and then writing 0xE1, is a valid key.
- R6: With the block enabled and `tick` high every cycle, `resetReq` rises exactly 2^(14+rate) ticks after the valid key edge.
- R7: `resetReq` lasts exactly one clock. In that same cycle `ctrlValue[0]` reads 0. No further request follows while the block stays disabled.
- R8: A valid key written mid-window restarts the full window. The next request comes 2^(14+rate) ticks after the refresh.
- R9: Cycles with `tick` low do not advance the count.
- R10: If a valid key arrives in the same cycle as the tick that would overflow the counter, the refresh wins. No request is raised and the block stays enabled.
- R11: Writes to addresses other than 0xA6 and 0xA7 change nothing. They do not disturb the last-byte record either.
- R12: A synchronous reset clears the last-byte record. A 0x1E written before the reset does not pair with a 0xE1 written after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |
| tick | input | 1 | One pulse per machine cycle |
| resetReq | output | 1 | One-clock reset request on timeout |
| ctrlValue | output | 8 | Read-back value of the control register, enable in bit 0 |

## Verification
A refresh and a timeout can land in the same clock: a valid 0xE1 key write, and the tick that carries the counter past its maximum. The bench provokes this by counting ticks from a known key edge. It writes 0x1E partway through the window, then presents 0xE1 on exactly the 16384th tick. It judges the outcome on three points: `resetReq` stays low on that edge, `ctrlValue[0]` stays 1, and the next request comes a full window later.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Strobes from the control side to the elapsed-count datapath
  typedef struct packed {
    logic clear;  // restart the elapsed count
    logic step;   // advance the elapsed count by one
  } cntStrobe_t;

  // Fixed bit positions inside the control register
  localparam int ENABLE_POS = 0;
  localparam int HWMODE_POS = 2;

endpackage

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PS_W = 3,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hA6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hA7,
  parameter logic [DATA_W-1:0] KEY_FIRST = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  input  logic              expire,
  output cntStrobe_t        strobe,
  output logic [DATA_W-1:0] ctrlValue
);

  localparam int PRE_W = (2 ** PS_W) - 1;
  localparam int RATE_TOP = DATA_W - 1;

  logic [DATA_W-1:1] ctrlHi;
  logic              enable;
  logic [DATA_W-1:0] prevKey;
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preMask;
  logic [PS_W-1:0]   rate;
  logic              keyHit;
  logic              ctrlHit;
  logic              keyValid;
  logic              preTerm;

  assign rate = ctrlHi[RATE_TOP -: PS_W];

  // Thermometer mask: 2^rate - 1
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign preMask[i] = (rate > PS_W'(i));
  end

  assign keyHit   = wrEn && (wrAddr == KEY_ADDR);
  assign ctrlHit  = wrEn && (wrAddr == CTRL_ADDR);
  assign keyValid = keyHit && (wrData == KEY_SECOND) && (prevKey == KEY_FIRST)
                    && ctrlHi[HWMODE_POS];
  assign preTerm  = ((preCnt & preMask) == preMask);

  assign strobe.clear = keyValid;
  assign strobe.step  = enable && tick && preTerm && !keyValid;

  assign ctrlValue = {ctrlHi, enable};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlHi  <= '0;
      enable  <= 1'b0;
      prevKey <= '0;
      preCnt  <= '0;
    end else begin
      if (keyHit) prevKey <= wrData;
      if (ctrlHit) ctrlHi <= wrData[DATA_W-1:1];
      if (keyValid) begin
        enable <= 1'b1;
        preCnt <= '0;
      end else if (expire) begin
        enable <= 1'b0;
        preCnt <= '0;
      end else if (enable && tick) begin
        preCnt <= preTerm ? '0 : preCnt + 1'b1;
      end
    end
  end

  // R3
  key_enable_chk: assert property (@(posedge clk) disable iff (rst)
    keyValid |=> enable && (preCnt == '0));

  // R7
  expire_disable_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> !enable);

  // R4
  enable_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(enable) |-> $past(keyValid));

  // R9
  idle_prescale_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !keyValid && !expire) |=> $stable(preCnt));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  cntStrobe_t strobe,
  output logic       expire,
  output logic       resetReq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count;

  assign expire = strobe.step && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= expire;
      if (strobe.clear) count <= '0;
      else if (strobe.step) count <= count + 1'b1;
    end
  end

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    resetReq |=> !resetReq);

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> !resetReq && (count == '0));

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.step && !strobe.clear) |=> $stable(count));

  // R6
  request_source_chk: assert property (@(posedge clk) disable iff (rst)
    resetReq |-> $past(strobe.step));

endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PS_W = 3,
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  output logic              resetReq,
  output logic [DATA_W-1:0] ctrlValue
);

  cntStrobe_t strobe;
  logic       expire;

  wdt_control #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .PS_W(PS_W)
  ) u_control (
    .clk(clk),
    .rst(rst),
    .wrEn(wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .tick(tick),
    .expire(expire),
    .strobe(strobe),
    .ctrlValue(ctrlValue)
  );

  wdt_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .expire(expire),
    .resetReq(resetReq)
  );

endmodule

// File: tb/tb_seq_watchdog.sv
`timescale 1ns/1ps
module tb_seq_watchdog;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       tick = 1'b0;
  logic       resetReq;
  logic [7:0] ctrlValue;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seq_watchdog dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tick(tick), .resetReq(resetReq), .ctrlValue(ctrlValue)
  );

  // {requirement, addr, data, expected ctrlValue}; tick held low
  localparam logic [31:0] VEC [13] = '{
    {8'd2,  8'hA7, 8'h04, 8'h04},  // R2 hardware mode on
    {8'd4,  8'hA6, 8'hE1, 8'h04},  // R4 no preceding first byte
    {8'd4,  8'hA6, 8'h1E, 8'h04},
    {8'd4,  8'hA6, 8'h55, 8'h04},
    {8'd4,  8'hA6, 8'hE1, 8'h04},  // R4 broken sequence
    {8'd2,  8'hA7, 8'hE5, 8'hE4},  // R2 data bit 0 ignored
    {8'd2,  8'hA7, 8'h00, 8'h00},
    {8'd5,  8'hA6, 8'h1E, 8'h00},
    {8'd5,  8'hA6, 8'hE1, 8'h00},  // R5 hardware mode clear
    {8'd5,  8'hA6, 8'h1E, 8'h00},
    {8'd5,  8'hA7, 8'h04, 8'h04},
    {8'd11, 8'h80, 8'hE1, 8'h04},  // R11 foreign address
    {8'd3,  8'hA6, 8'hE1, 8'h05}   // R3 valid after R5 tracking
  };

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic stepCycle(input logic t, input logic we,
                           input logic [7:0] a, input logic [7:0] d);
    tick = t; wrEn = we; wrAddr = a; wrData = d;
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    stepCycle(1'b0, 1'b1, a, d);
    wrEn = 1'b0;
  endtask

  task automatic runUntilPulse(input int mode, input int limit, output int n);
    n = -1;
    for (int c = 1; c <= limit; c++) begin
      stepCycle((mode == 0) ? 1'b1 : c[0], 1'b0, 8'h00, 8'h00);
      if (resetReq) begin
        n = c;
        return;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int pulses;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    checkEq("R1 resetReq", int'(resetReq), 0);
    checkEq("R1 ctrlValue", int'(ctrlValue), 0);
    rst = 1'b0;

    // Table of key/control writes
    for (int i = 0; i < 13; i++) begin
      writeReg(VEC[i][23:16], VEC[i][15:8]);
      checkEq($sformatf("R%0d vector %0d ctrlValue", VEC[i][31:24], i),
              int'(ctrlValue), int'(VEC[i][7:0]));
    end

    // R6 timeout at rate 0
    runUntilPulse(0, 40000, n);
    checkEq("R6 ticks to request rate0", n, 16384);
    checkEq("R7 enable clear with request", int'(ctrlValue[0]), 0);
    stepCycle(1'b1, 1'b0, 8'h00, 8'h00);
    checkEq("R7 request one clock", int'(resetReq), 0);
    pulses = 0;
    for (int c = 0; c < 200; c++) begin
      stepCycle(1'b1, 1'b0, 8'h00, 8'h00);
      if (resetReq) pulses++;
    end
    checkEq("R7 no request while disabled", pulses, 0);

    // R6 timeout at rate 1
    writeReg(8'hA7, 8'h24);
    writeReg(8'hA6, 8'h1E);
    writeReg(8'hA6, 8'hE1);
    checkEq("R3 enable at rate1", int'(ctrlValue), 8'h25);
    runUntilPulse(0, 40000, n);
    checkEq("R6 ticks to request rate1", n, 32768);

    // R9 tick low cycles do not count
    writeReg(8'hA7, 8'h04);
    writeReg(8'hA6, 8'h1E);
    writeReg(8'hA6, 8'hE1);
    runUntilPulse(1, 40000, n);
    checkEq("R9 cycles with alternating tick", n, 32767);

    // R10 and R8: refresh on the overflow tick
    writeReg(8'hA6, 8'h1E);
    stepCycle(1'b1, 1'b1, 8'hA6, 8'hE1);
    pulses = 0;
    for (int c = 1; c <= 16384; c++) begin
      if (c == 16000) stepCycle(1'b1, 1'b1, 8'hA6, 8'h1E);
      else if (c == 16384) stepCycle(1'b1, 1'b1, 8'hA6, 8'hE1);
      else stepCycle(1'b1, 1'b0, 8'h00, 8'h00);
      if (resetReq) pulses++;
    end
    checkEq("R10 no request on refresh edge", pulses, 0);
    checkEq("R10 still enabled", int'(ctrlValue[0]), 1);
    runUntilPulse(0, 40000, n);
    checkEq("R8 full window after refresh", n, 16384);

    // R12 reset clears last-byte record
    writeReg(8'hA7, 8'h04);
    writeReg(8'hA6, 8'h1E);
    rst = 1'b1;
    stepCycle(1'b0, 1'b0, 8'h00, 8'h00);
    rst = 1'b0;
    checkEq("R1 ctrlValue after reset", int'(ctrlValue), 0);
    writeReg(8'hA7, 8'h04);
    writeReg(8'hA6, 8'hE1);
    checkEq("R12 key not paired across reset", int'(ctrlValue), 8'h04);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule